// File: doc/BRIEF.md
# Speculative Shared Function Unit for an Elastic Multiplexer

This block puts one copy of a combinational function F behind a multiplexer that has several elastic data inputs and an elastic select channel. F is not replicated for each input. A last-choice predictor names one channel each cycle, and F is evaluated on that channel's token. The result waits in a per-channel result slot until the select token arrives. Every channel other than the predicted one is held off through its stop signal. All channels use a valid/stop handshake. A token moves on a channel in a cycle where valid is high and stop is low. The sender keeps valid and data steady while stop is high.

When the select token names a channel whose result is already held, the output token leaves in that same cycle, so a correct guess costs nothing. When the select names a channel with no held result, the predictor takes the select value and F runs on that channel in the next cycle. The result leaves one cycle after that, which is a two-cycle penalty. A result already computed for a channel that was not selected is kept and used when that channel is chosen later. The output stream therefore matches, token for token and in order, a plain multiplexer that has its own copy of F on every input.

Top module: `spec_shared_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and sel_stop is 1. The prediction is channel 0, so in_stop is 0 only on channel 0 and 1 on every other channel.
- R2: In every cycle, at most one input channel has in_stop low, and that channel is the predicted one. All other inputs are stopped. A token is taken from an input only when F is evaluated on it.
- R3: After each cycle with sel_valid high, the prediction becomes the value of sel_idx in that cycle. This is seen at the ports as the channel whose in_stop goes low.
- R4: out_valid is high only when sel_valid is high and the result slot of the channel named by sel_idx holds a result. out_data is F applied to that channel's oldest unselected token. With default parameters F(d) = (d rotated left by one bit) + 8'h5A, on 8-bit data.
- R5: A token captured for the predicted channel appears at the output one cycle after capture, provided the select is already present. If the result is already held when the select token arrives, out_valid rises in the same cycle as sel_valid.
- R6: On a misprediction, meaning the select names a channel whose slot is empty while that channel's input token waits, out_valid rises exactly two cycles after sel_valid.
- R7: The sequence of output tokens equals, in order and value, the sequence given by a non-speculative multiplexer with one F per input. Each select token consumes the oldest token of the named channel.
- R8: While out_valid is high and out_stop is high, the output token stays valid with unchanged data and the select token is not consumed (sel_stop stays 1).
- R9: A result computed speculatively for a channel that was not selected is not lost. When that channel is selected later, its result is emitted in the same cycle as the select, and no further input token is taken for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_CH | Valid per data input channel |
| in_data | input | N_CH*W | Data per input channel, channel c at bits [c*W +: W] |
| in_stop | output | N_CH | Stop per input channel (1 = token not taken) |
| sel_valid | input | 1 | Select token valid |
| sel_idx | input | SEL_W | Channel chosen by the select token |
| sel_stop | output | 1 | Stop for the select channel |
| out_valid | output | 1 | Output token valid |
| out_data | output | W | F of the selected channel's token |
| out_stop | input | 1 | Stop from the output receiver |

## Verification
Two functions can meet in a single cycle: the output pop of a channel's result slot and the speculative capture of the next token into that same slot. The bench causes this by sending back-to-back tokens on one channel while the select stays on it, and it judges the result with the scoreboard, which requires the values to come out in order with none lost or repeated. The other collision is a misprediction on one channel while the other channel's slot still holds a speculative result. Directed sequences reach this case and check both the two-cycle delay and the value from the kept slot when that channel is selected later.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
   typedef enum logic [0:0] {
      FN_ROT_ADD  = 1'b0,
      FN_GRAY_XOR = 1'b1
   } fn_kind_e;
endpackage

// File: rtl/shared_fu.sv
module shared_fu
   import ssu_pkg::*;
#(
   parameter int       W    = 8,
   parameter fn_kind_e FN   = FN_ROT_ADD,
   parameter int       KEY  = 'h5A
) (
   input  logic [W-1:0] op,
   output logic [W-1:0] res
);
   localparam logic [W-1:0] KEY_W = W'(KEY);

   generate
      if (W < 2) begin : g_bad_width
         $error("shared_fu: W must be at least 2");
      end
      if (FN == FN_ROT_ADD) begin : g_rot_add
         always_comb res = {op[W-2:0], op[W-1]} + KEY_W;
      end else begin : g_gray_xor
         always_comb res = (op ^ (op >> 1)) ^ KEY_W;
      end
   endgenerate
endmodule

// File: rtl/result_slot.sv
module result_slot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         full,
   output logic [W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else begin
         if (push) begin
            full <= 1'b1;
            data <= push_data;
         end else if (pop) begin
            full <= 1'b0;
         end
      end
   end

   // R7: a held result is never overwritten before it has been emitted
   assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |-> !push);
   // R7: a pop only ever drains a filled slot
   assert_pop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> full);
endmodule

// File: rtl/fu_scheduler.sv
module fu_scheduler #(
   parameter int N_CH  = 2,
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_valid,
   input  logic [SEL_W-1:0] sel_idx,
   input  logic [N_CH-1:0]  slot_full,
   input  logic             out_stop,
   output logic [SEL_W-1:0] pred,
   output logic             out_valid,
   output logic             sel_stop,
   output logic [N_CH-1:0]  slot_pop,
   output logic [N_CH-1:0]  take_ok
);
   logic fire;

   always_comb begin
      out_valid = sel_valid && slot_full[sel_idx];
      fire      = out_valid && !out_stop;
      sel_stop  = !fire;
      for (int c = 0; c < N_CH; c++) begin
         slot_pop[c] = fire && (sel_idx == SEL_W'(c));
         take_ok[c]  = (pred == SEL_W'(c)) && (!slot_full[c] || slot_pop[c]);
      end
   end

   // last-choice predictor, reset to channel 0
   always_ff @(posedge clk) begin
      if (!rst_n) pred <= '0;
      else if (sel_valid) pred <= sel_idx;
   end

   // R2: the shared unit accepts from at most one channel per cycle
   assert_single_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_ok));
   // R6: a select that finds no held result retargets the unit next cycle
   assert_retarget_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !slot_full[sel_idx]) |=> (pred == $past(sel_idx)));
endmodule

// File: rtl/spec_shared_unit.sv
module spec_shared_unit
   import ssu_pkg::*;
#(
   parameter int       W    = 8,
   parameter int       N_CH = 2,
   parameter fn_kind_e FN   = FN_ROT_ADD,
   parameter int       KEY  = 'h5A,
   localparam int      SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   in_valid,
   input  logic [N_CH*W-1:0] in_data,
   output logic [N_CH-1:0]   in_stop,
   input  logic              sel_valid,
   input  logic [SEL_W-1:0]  sel_idx,
   output logic              sel_stop,
   output logic              out_valid,
   output logic [W-1:0]      out_data,
   input  logic              out_stop
);
   generate
      if (N_CH < 2 || (1 << SEL_W) != N_CH) begin : g_bad_nch
         $error("spec_shared_unit: N_CH must be a power of two, at least 2");
      end
   endgenerate

   logic [SEL_W-1:0] pred;
   logic [N_CH-1:0]  slot_full, slot_pop, take_ok, slot_push;
   logic [W-1:0]     slot_data [N_CH];
   logic [W-1:0]     fu_op, fu_res;

   fu_scheduler #(.N_CH(N_CH), .SEL_W(SEL_W)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_valid (sel_valid),
      .sel_idx   (sel_idx),
      .slot_full (slot_full),
      .out_stop  (out_stop),
      .pred      (pred),
      .out_valid (out_valid),
      .sel_stop  (sel_stop),
      .slot_pop  (slot_pop),
      .take_ok   (take_ok)
   );

   // single copy of F, fed by the predicted channel
   always_comb fu_op = in_data[pred*W +: W];

   shared_fu #(.W(W), .FN(FN), .KEY(KEY)) u_fu (
      .op  (fu_op),
      .res (fu_res)
   );

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_slot
         always_comb begin
            in_stop[c]   = !take_ok[c];
            slot_push[c] = in_valid[c] && take_ok[c];
         end
         result_slot #(.W(W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (slot_push[c]),
            .push_data (fu_res),
            .pop       (slot_pop[c]),
            .full      (slot_full[c]),
            .data      (slot_data[c])
         );
      end
   endgenerate

   always_comb out_data = slot_data[sel_idx];

   // R4: no output token without a select token
   assert_out_needs_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> sel_valid);
   // R8: a stalled output token stays put
   assert_hold_under_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_stop) |=> (out_valid && $stable(out_data)));
   // R8: the select is not consumed while the output is stalled
   assert_sel_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_stop |-> sel_stop);
   // R2: at most one input is open in any cycle
   assert_one_open_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~in_stop));
endmodule

// File: tb/tb_spec_shared_unit.sv
module tb_spec_shared_unit;
   localparam int PER = 10;
   localparam int W = 8;
   localparam int NS = 80;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [1:0]  in_valid = '0;
   logic [15:0] in_data = '0;
   logic [1:0]  in_stop;
   logic        sel_valid = 0;
   logic        sel_idx = 0;
   logic        sel_stop;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_stop = 0;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] exp_q[$];

   always #(PER/2) clk = ~clk;

   spec_shared_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_stop(in_stop), .sel_valid(sel_valid), .sel_idx(sel_idx),
      .sel_stop(sel_stop), .out_valid(out_valid), .out_data(out_data),
      .out_stop(out_stop)
   );

   function automatic logic [7:0] fref(input logic [7:0] d);
      return {d[6:0], d[7]} + 8'h5A;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic push_expected(input logic [7:0] v);
      exp_q.push_back(v);
   endtask

   initial begin
      #(PER * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] chd [2][NS];
      logic       seq [NS];
      int         cnt [2];
      int         rd_ptr [2];
      int         sel_ptr;
      bit         pend [2];
      bit         spend;
      int         cyc;
      logic       s;

      // ---------- R1: reset state
      repeat (3) tick();
      settle();
      chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
      chk(in_stop == 2'b10, "R1 in_stop in reset", in_stop, 2'b10);
      rst_n = 1;
      tick(); settle();
      chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
      chk(sel_stop == 1, "R1 sel_stop after reset", sel_stop, 1);
      chk(in_stop == 2'b10, "R1 prediction is channel 0", in_stop, 2'b10);

      // ---------- R4/R5: captured token emitted one cycle later
      in_valid = 2'b01; in_data[7:0] = 8'h13; sel_valid = 1; sel_idx = 0;
      settle();
      chk(out_valid == 0, "R4 no result held yet", out_valid, 0);
      tick(); in_valid = 2'b00; settle();
      chk(out_valid == 1, "R5 output one cycle after capture", out_valid, 1);
      chk(out_data == fref(8'h13), "R4 F value", out_data, fref(8'h13));
      tick(); sel_valid = 0; settle();
      chk(out_valid == 0, "R4 no select no output", out_valid, 0);

      // ---------- R5: held result, no extra cycle
      in_valid = 2'b01; in_data[7:0] = 8'hC4;
      tick(); in_valid = 2'b00; settle();
      chk(out_valid == 0, "R4 held result waits for select", out_valid, 0);
      tick(); sel_valid = 1; sel_idx = 0; settle();
      chk(out_valid == 1, "R5 same-cycle emission", out_valid, 1);
      chk(out_data == fref(8'hC4), "R5 value", out_data, fref(8'hC4));
      tick(); sel_valid = 0;

      // ---------- R6/R2/R3/R8: misprediction to channel 1
      in_valid = 2'b10; in_data[15:8] = 8'h7E; sel_valid = 1; sel_idx = 1;
      settle();
      chk(out_valid == 0, "R6 no output at select", out_valid, 0);
      chk(in_stop == 2'b10, "R2 unpredicted channel stopped", in_stop, 2'b10);
      tick(); settle();
      chk(in_stop == 2'b01, "R3 prediction follows select", in_stop, 2'b01);
      chk(out_valid == 0, "R6 still stalled", out_valid, 0);
      tick(); in_valid = 2'b00; out_stop = 1; settle();
      chk(out_valid == 1, "R6 output two cycles after select", out_valid, 1);
      chk(out_data == fref(8'h7E), "R6 value", out_data, fref(8'h7E));
      tick(); settle();
      chk(out_valid == 1 && out_data == fref(8'h7E), "R8 held under stop", out_data, fref(8'h7E));
      chk(sel_stop == 1, "R8 select not consumed", sel_stop, 1);
      tick(); out_stop = 0; settle();
      chk(sel_stop == 0, "R8 select consumed once released", sel_stop, 0);
      tick(); sel_valid = 0;

      // ---------- R9: speculative result of unselected channel kept
      in_valid = 2'b01; in_data[7:0] = 8'hA1; sel_valid = 1; sel_idx = 0;
      tick();
      tick(); in_data[7:0] = 8'h5C; settle();
      chk(out_data == fref(8'hA1) && out_valid, "R9 first ch0 value", out_data, fref(8'hA1));
      tick(); in_valid = 2'b10; in_data[15:8] = 8'h39; sel_idx = 1; settle();
      chk(out_valid == 0, "R6 mispredict towards ch1", out_valid, 0);
      tick();
      tick(); in_valid = 2'b00; settle();
      chk(out_valid == 1 && out_data == fref(8'h39), "R6 ch1 value", out_data, fref(8'h39));
      tick(); sel_idx = 0; settle();
      chk(out_valid == 1, "R9 kept result emitted with select", out_valid, 1);
      chk(out_data == fref(8'h5C), "R9 kept value", out_data, fref(8'h5C));
      chk(in_stop[0] == 1, "R9 no input taken while predicting ch1", in_stop[0], 1);
      tick(); sel_valid = 0;
      repeat (2) tick();
      settle();
      chk(out_valid == 0, "R9 slot drained", out_valid, 0);

      // ---------- R7: scoreboard on a long stream
      cnt[0] = 0; cnt[1] = 0; s = 0;
      for (int k = 0; k < NS; k++) begin
         if ($urandom % 100 < 20) s = ~s;
         seq[k] = s;
         chd[s][cnt[s]] = 8'($urandom);
         push_expected(fref(chd[s][cnt[s]]));
         cnt[s]++;
      end
      rd_ptr[0] = 0; rd_ptr[1] = 0; sel_ptr = 0;
      pend[0] = 0; pend[1] = 0; spend = 0;
      cyc = 0;
      while (exp_q.size() != 0 && cyc < 3000) begin
         tick();
         for (int c = 0; c < 2; c++) begin
            if (!pend[c] && rd_ptr[c] < cnt[c] && ($urandom % 4 != 0)) begin
               pend[c] = 1;
               in_data[c*8 +: 8] = chd[c][rd_ptr[c]];
            end
            in_valid[c] = pend[c];
         end
         if (!spend && sel_ptr < NS && ($urandom % 5 != 0)) begin
            spend = 1;
            sel_idx = seq[sel_ptr];
         end
         sel_valid = spend;
         out_stop = ($urandom % 5 == 0);
         settle();
         if (in_stop == 2'b00) chk(0, "R2 two inputs open", in_stop, 2'b11);
         if (out_valid && !sel_valid) chk(0, "R4 output without select", out_valid, 0);
         if (out_valid && !out_stop) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(out_data == e, "R7 stream order and value", out_data, e);
         end
         for (int c = 0; c < 2; c++)
            if (in_valid[c] && !in_stop[c]) begin
               pend[c] = 0;
               rd_ptr[c]++;
            end
         if (sel_valid && !sel_stop) begin
            spend = 0;
            sel_ptr++;
         end
         cyc++;
      end
      chk(exp_q.size() == 0, "R7 all tokens delivered", exp_q.size(), 0);
      tick();
      in_valid = '0; sel_valid = 0; out_stop = 0;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule